// File: doc/BRIEF.md
# Sector Safe-Guard and Unlock Unit

This unit sits beside the command decoder of a serial flash and holds a per-sector write guard. There is one guard bit for each 4 KB sector, and a zero bit means the sector is guarded. A configuration byte holds a chip-erase permit. A single-sector unlock register is also kept here. The guard bits are stored in registers, not in the array. The decoder delivers each completed command frame as a stream of beats. A header beat carries the opcode, the 24-bit address and the total bit count of the frame. Any data bytes of the frame follow as data beats, and the last beat of the frame is flagged.

The unit watches these frames for two five-frame key handshakes. One handshake erases all guard state to ones. The other ANDs data bytes into the guard bytes. Any frame that breaks a handshake drops it. A readback opcode streams guard bytes out through a valid/ready port. A combinational query gives the write decision for an address. The guard bit comes first, and block protection, opened by the unlock register for one sector, comes second.

Back-pressure rules: a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output byte transfers where `out_valid` and `out_ready` are both high. `in_ready` is low while any readback byte is still owed. While `out_valid` is high and `out_ready` is low, `out_data` holds.

Top module: `sg_guard_unit`

## Requirements
- R1: After reset, every guard bit and every bit of the configuration byte is 1. `chip_erase_ok` is 1, `unlock_active` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: Sector s = addr[17:12] uses bit s%8 of guard byte s/8, where guard bytes 0..7 are register addresses 0..7. Address bits 23:18 are ignored. If that bit is 0, `q_writable` is 0 whatever the block protection and unlock state.
- R3: If the guard bit of the queried sector is 1, then `q_writable` is 1 when `q_bp_prot` is 0. When `q_bp_prot` is 1, `q_writable` is 1 only if an unlock is active for that same sector.
- R4: The header sequence 55h/32 bits, AAh/32, 80h/32, AAh/32, 2Bh/8 sets all guard bits and the configuration byte to ones. The address values in these frames do not matter.
- R5: A header that does not match the next expected step cancels the sequence, and nothing is changed. A header of 55h/32 bits always starts a new sequence at step one.
- R6: The header sequence 55h/32, AAh/32, A0h/32, 55h/32, then 23h with a bit count of at least 40 and a multiple of 8, arms a program. The following data beats of that frame are ANDed into register bytes from address in_addr[3:0]. The pointer steps up by one per byte and wraps from 8 to 0. Pointers 9..15 write nothing and step on to 0 after 15.
- R7: A program only clears bits. Writing 1 to a bit that is already 0 leaves it 0.
- R8: Header 2Fh with bit count N and last set streams floor((N-32)/8) bytes, starting at register address in_addr[3:0]. The pointer steps as in R6, and pointers 9..15 read 00h.
- R9: While readback bytes are owed, `in_ready` is 0. A byte that is offered and not taken stays on `out_data`.
- R10: Header 26h is accepted as an unlock only if `wel` is 1, the bit count is exactly 32 and in_addr[11:0] is zero. It then records sector in_addr[17:12].
- R11: While an unlock is active, further unlock headers are refused and the sector stays unchanged. Header 24h with bit count 8 clears the unlock.
- R12: `chip_erase_ok` follows bit 0 of the configuration byte at register address 8.
- R13: Any other opcode between handshake frames, including 2Fh, 26h and 24h, returns the sequence to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Frame beat accepted this edge when high |
| in_hdr | input | 1 | Beat is a header (1) or a data byte (0) |
| in_op | input | 8 | Header opcode |
| in_addr | input | 24 | Header address |
| in_nbits | input | 16 | Header total bit count of the frame |
| in_data | input | 8 | Data beat byte |
| in_last | input | 1 | Last beat of the frame |
| wel | input | 1 | Write enable latch state |
| out_valid | output | 1 | Readback byte valid |
| out_ready | input | 1 | Readback byte taken |
| out_data | output | 8 | Readback byte |
| q_addr | input | 24 | Query address |
| q_bp_prot | input | 1 | Query address lies in a block-protected area |
| q_writable | output | 1 | Write decision for the query address |
| chip_erase_ok | output | 1 | Chip erase permitted |
| unlock_active | output | 1 | A sector is unlocked |
| unlock_sector | output | 6 | Unlocked sector index |

## Verification
The handshakes are driven in four forms: exact, broken at the third step by a near-miss opcode, interrupted by an unrelated readback, and restarted by a repeated 55h. These separate the abort path from the restart path and from a real erase. Program frames that start at byte 7, run through the configuration byte and wrap to byte 0 check the pointer wrap and the clear-only rule. Readbacks that start in the unused addresses 14..15 show the zero fill. Unlock headers are tried with the write latch off, with a low address bit set, with 40 bits and in the correct form, and then again while one is active and after a lock. This shows which of the guard bit, block protection and unlock controls `q_writable`.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam logic [7:0] OP_KEY_A     = 8'h55;
  localparam logic [7:0] OP_KEY_B     = 8'hAA;
  localparam logic [7:0] OP_ERASE_ARM = 8'h80;
  localparam logic [7:0] OP_PROG_ARM  = 8'hA0;
  localparam logic [7:0] OP_ERASE_GO  = 8'h2B;
  localparam logic [7:0] OP_PROG_GO   = 8'h23;
  localparam logic [7:0] OP_READBACK  = 8'h2F;
  localparam logic [7:0] OP_UNLOCK    = 8'h26;
  localparam logic [7:0] OP_LOCK      = 8'h24;

  localparam int ADDR_FRAME_BITS = 32;
  localparam int OP_ONLY_BITS    = 8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_E3, SQ_P3, SQ_E4, SQ_P4
  } seq_t;
endpackage

// File: rtl/sg_seq_fsm.sv
module sg_seq_fsm
  import sg_pkg::*;
#(
  parameter int NB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hdr_fire,
  input  logic [7:0]      op,
  input  logic [NB_W-1:0] nbits,
  output logic            erase_go,
  output logic            prog_go
);
  seq_t st, nxt;
  logic addr_ok, key_a, prog_len_ok;
  seq_t restart;

  assign addr_ok     = (nbits == NB_W'(ADDR_FRAME_BITS));
  assign key_a       = (op == OP_KEY_A) && addr_ok;
  assign restart     = key_a ? SQ_K1 : SQ_IDLE;
  assign prog_len_ok = (nbits >= NB_W'(ADDR_FRAME_BITS + 8)) && (nbits[2:0] == 3'b000);

  always_comb begin
    nxt      = st;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    if (hdr_fire) begin
      unique case (st)
        SQ_IDLE: nxt = restart;
        SQ_K1:   nxt = (op == OP_KEY_B && addr_ok) ? SQ_K2 : restart;
        SQ_K2: begin
          if (op == OP_ERASE_ARM && addr_ok)     nxt = SQ_E3;
          else if (op == OP_PROG_ARM && addr_ok) nxt = SQ_P3;
          else                                   nxt = restart;
        end
        SQ_E3:   nxt = (op == OP_KEY_B && addr_ok) ? SQ_E4 : restart;
        SQ_P3:   nxt = key_a ? SQ_P4 : restart;
        SQ_E4: begin
          if (op == OP_ERASE_GO && nbits == NB_W'(OP_ONLY_BITS)) begin
            erase_go = 1'b1;
            nxt      = SQ_IDLE;
          end else begin
            nxt = restart;
          end
        end
        SQ_P4: begin
          if (op == OP_PROG_GO && prog_len_ok) begin
            prog_go = 1'b1;
            nxt     = SQ_IDLE;
          end else begin
            nxt = restart;
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/sg_bit_store.sv
module sg_bit_store #(
  parameter int REG_BYTES = 9,
  parameter int PTR_W     = 4,
  localparam int BITS_N   = 8 * REG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_go,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [7:0]        wr_byte,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [7:0]        rd_byte,
  output logic [BITS_N-1:0] bits
);
  always_ff @(posedge clk) begin
    if (!rst_n || erase_go) begin
      bits <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < REG_BYTES; i++) begin
        if (wr_ptr == PTR_W'(i)) bits[8*i +: 8] <= bits[8*i +: 8] & wr_byte;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < REG_BYTES; i++) begin
      if (rd_ptr == PTR_W'(i)) rd_byte = bits[8*i +: 8];
    end
  end
endmodule

// File: rtl/sg_read_engine.sv
module sg_read_engine #(
  parameter int REG_BYTES = 9,
  parameter int PTR_W     = 4,
  parameter int NB_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [NB_W-1:0]  start_len,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic [7:0]       rd_byte,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_BYTES - 1);
  logic [NB_W-1:0] remain;

  assign busy      = (remain != '0);
  assign out_valid = busy;
  assign out_data  = rd_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      rd_ptr <= '0;
    end else if (start && !busy) begin
      remain <= start_len;
      rd_ptr <= start_ptr;
    end else if (busy && out_ready) begin
      remain <= remain - 1'b1;
      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sg_unlock_reg.sv
module sg_unlock_reg
  import sg_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int NB_W       = 16,
  parameter int SECT_SHIFT = 12,
  parameter int SECT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB_W-1:0]   nbits,
  input  logic              wel,
  output logic              active,
  output logic [SECT_W-1:0] sector
);
  logic try_open, do_lock;

  assign try_open = hdr_fire && (op == OP_UNLOCK) && (nbits == NB_W'(ADDR_FRAME_BITS))
                    && (addr[SECT_SHIFT-1:0] == '0) && wel && !active;
  assign do_lock  = hdr_fire && (op == OP_LOCK) && (nbits == NB_W'(OP_ONLY_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sector <= '0;
    end else if (do_lock) begin
      active <= 1'b0;
    end else if (try_open) begin
      active <= 1'b1;
      sector <= addr[SECT_SHIFT +: SECT_W];
    end
  end
endmodule

// File: rtl/sg_guard_unit.sv
module sg_guard_unit
  import sg_pkg::*;
#(
  parameter int NUM_SECT   = 64,
  parameter int SECT_SHIFT = 12,
  parameter int ADDR_W     = 24,
  parameter int NB_W       = 16,
  localparam int SECT_W    = $clog2(NUM_SECT),
  localparam int REG_BYTES = NUM_SECT / 8 + 1,
  localparam int PTR_W     = $clog2(REG_BYTES),
  localparam int BITS_N    = 8 * REG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_hdr,
  input  logic [7:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NB_W-1:0]   in_nbits,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              wel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_bp_prot,
  output logic              q_writable,
  output logic              chip_erase_ok,
  output logic              unlock_active,
  output logic [SECT_W-1:0] unlock_sector
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_BYTES - 1);

  logic hdr_fire, data_fire, erase_go, prog_go, rd_busy, prog_active, wr_en;
  logic [PTR_W-1:0]  prog_ptr, rd_ptr;
  logic [7:0]        rd_byte;
  logic [NB_W-1:0]   rd_len;
  logic [BITS_N-1:0] store_bits;
  logic [SECT_W-1:0] q_sect;

  assign in_ready  = !rd_busy;
  assign hdr_fire  = in_valid && in_ready && in_hdr;
  assign data_fire = in_valid && in_ready && !in_hdr;
  assign wr_en     = data_fire && prog_active;
  assign rd_len    = (in_nbits >= NB_W'(ADDR_FRAME_BITS + 8))
                     ? ((in_nbits - NB_W'(ADDR_FRAME_BITS)) >> 3) : '0;

  sg_seq_fsm #(.NB_W(NB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hdr_fire(hdr_fire), .op(in_op), .nbits(in_nbits),
    .erase_go(erase_go), .prog_go(prog_go)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_active <= 1'b0;
      prog_ptr    <= '0;
    end else if (hdr_fire) begin
      prog_active <= prog_go && !in_last;
      if (prog_go) prog_ptr <= in_addr[PTR_W-1:0];
    end else if (data_fire) begin
      if (prog_active) prog_ptr <= (prog_ptr == LAST) ? '0 : prog_ptr + 1'b1;
      if (in_last) prog_active <= 1'b0;
    end
  end

  sg_bit_store #(.REG_BYTES(REG_BYTES), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .wr_en(wr_en), .wr_ptr(prog_ptr),
    .wr_byte(in_data), .rd_ptr(rd_ptr), .rd_byte(rd_byte), .bits(store_bits)
  );

  sg_read_engine #(.REG_BYTES(REG_BYTES), .PTR_W(PTR_W), .NB_W(NB_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(hdr_fire && in_op == OP_READBACK),
    .start_ptr(in_addr[PTR_W-1:0]), .start_len(rd_len), .rd_ptr(rd_ptr), .rd_byte(rd_byte),
    .busy(rd_busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  sg_unlock_reg #(.ADDR_W(ADDR_W), .NB_W(NB_W), .SECT_SHIFT(SECT_SHIFT), .SECT_W(SECT_W)) u_ul (
    .clk(clk), .rst_n(rst_n), .hdr_fire(hdr_fire), .op(in_op), .addr(in_addr),
    .nbits(in_nbits), .wel(wel), .active(unlock_active), .sector(unlock_sector)
  );

  assign q_sect        = q_addr[SECT_SHIFT +: SECT_W];
  assign chip_erase_ok = store_bits[8 * (REG_BYTES - 1)];
  assign q_writable    = store_bits[q_sect] &&
                         (!q_bp_prot || (unlock_active && unlock_sector == q_sect));
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk
  import sg_pkg::*;
#(
  parameter int NB_W   = 16,
  parameter int SECT_W = 6,
  parameter int BITS_N = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_hdr,
  input logic [7:0]        in_op,
  input logic [NB_W-1:0]   in_nbits,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              unlock_active,
  input logic [SECT_W-1:0] unlock_sector,
  input logic              erase_go,
  input logic [BITS_N-1:0] bits
);
  logic lock_fire;
  assign lock_fire = in_valid && in_ready && in_hdr && in_op == OP_LOCK
                     && in_nbits == NB_W'(OP_ONLY_BITS);

  AST_READ_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> &bits); // R4
  AST_PROG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_go |=> ((bits & ~$past(bits)) == '0)); // R7
  AST_SINGLE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_active && !lock_fire |=> unlock_active && $stable(unlock_sector)); // R11
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fire |=> !unlock_active); // R11
endmodule

bind sg_guard_unit sg_guard_chk #(.NB_W(NB_W), .SECT_W(SECT_W), .BITS_N(BITS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
  .in_op(in_op), .in_nbits(in_nbits), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .unlock_active(unlock_active), .unlock_sector(unlock_sector),
  .erase_go(erase_go), .bits(store_bits)
);

// File: tb/sim_sg_guard_unit.sv
module sim_sg_guard_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_hdr, in_last, wel, out_valid, out_ready;
  logic q_bp_prot, q_writable, chip_erase_ok, unlock_active;
  logic [7:0] in_op, in_data, out_data;
  logic [23:0] in_addr, q_addr;
  logic [15:0] in_nbits;
  logic [5:0] unlock_sector;

  sg_guard_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
    .in_op(in_op), .in_addr(in_addr), .in_nbits(in_nbits), .in_data(in_data),
    .in_last(in_last), .wel(wel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .q_addr(q_addr), .q_bp_prot(q_bp_prot), .q_writable(q_writable),
    .chip_erase_ok(chip_erase_ok), .unlock_active(unlock_active), .unlock_sector(unlock_sector)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [71:0] mdl;
  logic ul_on;
  logic [5:0] ul_sec;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt_ptr(input logic [3:0] p);
    return (p == 4'd8) ? 4'd0 : p + 4'd1;
  endfunction

  function automatic logic [7:0] mdl_byte(input logic [3:0] p);
    return (p <= 4'd8) ? mdl[8*p +: 8] : 8'h00;
  endfunction

  function automatic logic exp_wr(input logic [23:0] a, input logic bp);
    return mdl[a[17:12]] && (!bp || (ul_on && ul_sec == a[17:12]));
  endfunction

  task automatic beat(input logic hdr, input logic [7:0] op, input logic [23:0] a,
                      input logic [15:0] nb, input logic [7:0] d, input logic last);
    @(negedge clk);
    in_valid = 1; in_hdr = hdr; in_op = op; in_addr = a; in_nbits = nb; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a, input logic [15:0] nb);
    beat(1, op, a, nb, 8'h00, 1);
  endtask

  task automatic query(input string tag, input logic [23:0] a, input logic bp);
    @(negedge clk);
    q_addr = a; q_bp_prot = bp;
    #1 chk(tag, {31'd0, q_writable}, {31'd0, exp_wr(a, bp)});
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] a, input int n);
    logic [3:0] p;
    p = a[3:0];
    hdr(8'h2F, a, 16'(32 + 8 * n));
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, {23'd0, out_valid, out_data}, {23'd0, 1'b1, mdl_byte(p)});
      p = nxt_ptr(p);
    end
    @(negedge clk);
    chk(tag, {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
  endtask

  task automatic do_erase();
    hdr(8'h55, 24'h000123, 32); hdr(8'hAA, 24'h000456, 32); hdr(8'h80, 0, 32);
    hdr(8'hAA, 0, 32); hdr(8'h2B, 0, 8);
    mdl = '1;
  endtask

  task automatic do_prog(input logic [23:0] a, input logic [7:0] d [3], input int n);
    logic [3:0] p;
    hdr(8'h55, 0, 32); hdr(8'hAA, 0, 32); hdr(8'hA0, 0, 32); hdr(8'h55, 0, 32);
    beat(1, 8'h23, a, 16'(32 + 8 * n), 8'h00, 0);
    p = a[3:0];
    for (int i = 0; i < n; i++) begin
      beat(0, 8'h00, 0, 0, d[i], i == n - 1);
      if (p <= 4'd8) mdl[8*p +: 8] = mdl[8*p +: 8] & d[i];
      p = nxt_ptr(p);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset flags", {28'd0, chip_erase_ok, unlock_active, out_valid, in_ready},
        {28'd0, 1'b1, 1'b0, 1'b0, 1'b1});
    rd_chk("R1 reset bytes", 0, 9);
  endtask

  task automatic t_program();
    logic [7:0] d [3];
    do_erase();
    rd_chk("R4 erase", 0, 9);
    d = '{8'hFE, 8'h00, 8'h00};
    do_prog(24'h000000, d, 1);
    query("R2 sector0 guarded", 24'h000000, 0);
    query("R2 sector1 open", 24'h001000, 0);
    d = '{8'h7F, 8'hFE, 8'hFD};
    do_prog(24'h000007, d, 3);
    @(negedge clk);
    chk("R12 chip erase bit", {31'd0, chip_erase_ok}, 32'd0);
    query("R2 sector63 guarded", 24'h03F000, 0);
    query("R2 upper bits ignored", 24'hC01000, 1);
    rd_chk("R6 wrap program", 0, 9);
    d = '{8'hFF, 8'h01, 8'h00};
    do_prog(24'h000000, d, 2);
    rd_chk("R7 clear only", 0, 2);
  endtask

  task automatic t_readback();
    rd_chk("R8 wrap read", 24'h000005, 12);
    rd_chk("R8 unused addr", 24'h00000E, 3);
  endtask

  task automatic t_abort();
    hdr(8'h55, 0, 32); hdr(8'hAA, 0, 32); hdr(8'h81, 0, 32); hdr(8'hAA, 0, 32); hdr(8'h2B, 0, 8);
    rd_chk("R5 abort no erase", 0, 9);
    hdr(8'h55, 0, 32); hdr(8'hAA, 0, 32); hdr(8'h2F, 0, 32); hdr(8'h80, 0, 32);
    hdr(8'hAA, 0, 32); hdr(8'h2B, 0, 8);
    rd_chk("R13 unrelated resets", 0, 9);
    hdr(8'h55, 0, 32); hdr(8'hAA, 0, 32);
    do_erase();
    @(negedge clk);
    chk("R5 restart erase", {31'd0, chip_erase_ok}, 32'd1);
    rd_chk("R5 restart bytes", 0, 9);
  endtask

  task automatic t_backpressure();
    logic [7:0] b0;
    out_ready = 0;
    hdr(8'h2F, 24'h000003, 48);
    @(negedge clk);
    b0 = out_data;
    chk("R9 first byte", {22'd0, out_valid, in_ready, b0}, {22'd0, 1'b1, 1'b0, mdl_byte(3)});
    repeat (3) begin
      @(negedge clk);
      chk("R9 held", {22'd0, out_valid, in_ready, out_data}, {22'd0, 1'b1, 1'b0, b0});
    end
    out_ready = 1;
    @(negedge clk);
    chk("R9 second byte", {23'd0, out_valid, out_data}, {23'd0, 1'b1, mdl_byte(4)});
    @(negedge clk);
    chk("R9 drained", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
  endtask

  task automatic t_unlock();
    logic [7:0] d [3];
    query("R3 bp guarded", 24'h003000, 1);
    wel = 0; hdr(8'h26, 24'h003000, 32);
    @(negedge clk); chk("R10 no wel", {31'd0, unlock_active}, 32'd0);
    wel = 1; hdr(8'h26, 24'h003001, 32);
    @(negedge clk); chk("R10 low bits", {31'd0, unlock_active}, 32'd0);
    hdr(8'h26, 24'h003000, 40);
    @(negedge clk); chk("R10 length", {31'd0, unlock_active}, 32'd0);
    hdr(8'h26, 24'h003000, 32); ul_on = 1; ul_sec = 3;
    @(negedge clk); chk("R10 accepted", {25'd0, unlock_active, unlock_sector}, {25'd0, 1'b1, 6'd3});
    query("R3 unlocked sector", 24'h003ABC, 1);
    query("R3 other sector bp", 24'h004000, 1);
    query("R3 no bp", 24'h004000, 0);
    hdr(8'h26, 24'h005000, 32);
    @(negedge clk); chk("R11 second refused", {25'd0, unlock_active, unlock_sector}, {25'd0, 1'b1, 6'd3});
    hdr(8'h24, 0, 8); ul_on = 0;
    @(negedge clk); chk("R11 lock", {31'd0, unlock_active}, 32'd0);
    hdr(8'h26, 24'h005000, 32); ul_on = 1; ul_sec = 5;
    @(negedge clk); chk("R11 reopen", {25'd0, unlock_active, unlock_sector}, {25'd0, 1'b1, 6'd5});
    query("R3 reopened sector", 24'h005000, 1);
    d = '{8'hDF, 8'h00, 8'h00};
    do_prog(24'h000000, d, 1);
    query("R2 guard beats unlock", 24'h005000, 1);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_hdr = 0; in_op = 0; in_addr = 0; in_nbits = 0; in_data = 0;
    in_last = 0; wel = 0; out_ready = 1; q_addr = 0; q_bp_prot = 0;
    mdl = '1; ul_on = 0; ul_sec = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_program();
    t_readback();
    t_abort();
    t_backpressure();
    t_unlock();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule